// File: doc/BRIEF.md
# Layered Band Compositor

This block builds a display image one horizontal band at a time out of stacked image layers. Layers reach it nearest first. Each incoming pixel carries its position in the band, a 24-bit colour and an 8-bit alpha. The block blends that pixel beneath the colour already collected at that position. Each position holds a running colour and a running coverage, so a layer that arrives later can only show through the part that earlier layers left uncovered. Once a position is fully covered, nothing that comes later changes it.

The block has two band buffers that it uses in turn. While the display side scans out a finished band from one buffer, the next band is composited into the other. The producer closes a band with `band_end`. The display side then requests that band with `disp_start`. Scan-out streams the pixels in raster order and zeroes each location as it reads it. A request that arrives when no finished band is waiting raises `underrun` for one cycle. The band size is set by parameters. A full display band is 1344 by 32, and the small defaults keep elaboration light.

Top module: `layer_band_compositor`

## Requirements
- R1: Reset starts a clearing sweep of both buffers that lasts BAND_W*BAND_H cycles. `comp_ready` stays low during the sweep and rises on the next cycle. `out_valid`, `band_done` and `underrun` are low, and a band that receives no pixels scans out as all zeros.
- R2: Colour is packed R in [23:16], G in [15:8] and B in [7:0]. Write div(x) for x/255 rounded to nearest. The first pixel at an empty position stores div(c*a) in each channel and stores coverage a.
- R3: A pixel that lands on existing coverage k uses the weight w = div(a*(255-k)). Each channel becomes its old value plus div(c*w), saturating at 255, and the coverage becomes k+w.
- R4: When a position's coverage is 255, any later pixel at that position leaves it unchanged.
- R5: One pixel is accepted per cycle while `pix_valid` and `comp_ready` are high. This holds even when consecutive pixels hit the same position.
- R6: Suppose `disp_start` is sampled high while a finished band is waiting. Then `out_valid` is first high two cycles after that sampling cycle and stays high for BAND_W*BAND_H consecutive cycles. The pixels come out in address order y*BAND_W+x, and `band_done` is high only with the last pixel.
- R7: Scan-out leaves the buffer zeroed. The next band composited into that buffer starts from empty.
- R8: `band_end` while `comp_ready` is high closes the current buffer and switches compositing to the other one. Compositing continues while a band is being scanned out. Bands scan out in the order they were closed.
- R9: If `disp_start` is sampled while no finished band is waiting and no scan-out is running, `underrun` is high for exactly the next cycle and no pixels are output.
- R10: When both buffers hold finished bands, `comp_ready` is low. `pix_valid` and `band_end` have no effect while `comp_ready` is low.
- R11: A pixel with x >= BAND_W or y >= BAND_H is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Layer pixel present |
| pix_x | input | X_W | Pixel column within the band |
| pix_y | input | Y_W | Pixel line within the band |
| pix_rgb | input | 24 | Pixel colour, R high byte |
| pix_alpha | input | 8 | Pixel opacity, 255 = opaque |
| band_end | input | 1 | All layers for the current band delivered |
| comp_ready | output | 1 | Pixels and band_end are accepted |
| disp_start | input | 1 | Display requests the next band |
| out_valid | output | 1 | Scan-out pixel present |
| out_rgb | output | 24 | Scan-out colour |
| band_done | output | 1 | Last pixel of the band |
| underrun | output | 1 | Request arrived with no band ready |

## Verification
The bench sends runs of back-to-back pixels to a single position. A design without read-after-write forwarding would blend each of those pixels onto stale data, and the final coverage and colour would come out too low. The bench sends opaque pixels first and then brighter ones to the same spot. A design that does not freeze a fully covered position would let the later pixels leak through. Out-of-range columns are chosen so that a design that drops no pixel would alias them onto a visible position in the next line. The bench also fills both buffers and then drives pixels and a band close. A design that did not hold these off would change the next scanned band or would fail to report the following underrun. Reusing a buffer after its scan-out catches a design that does not clear locations as it reads them.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    logic [7:0] cov;
  } cell_t;

  // nearest-integer x/255 for products of two bytes
  function automatic logic [7:0] div255r(input logic [15:0] x);
    logic [16:0] t;
    t = {1'b0, x} + 17'd128;
    return 8'((t + (t >> 8)) >> 8);
  endfunction

  function automatic logic [7:0] sat_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[8] ? 8'hFF : s[7:0];
  endfunction

  function automatic cell_t blend_under(input cell_t acc, input logic [23:0] rgb,
                                        input logic [7:0] alpha);
    cell_t      res;
    logic [7:0] w;
    res = acc;
    if (acc.cov != 8'hFF) begin
      w       = div255r(16'(alpha) * 16'(8'hFF - acc.cov));
      res.r   = sat_add(acc.r, div255r(16'(rgb[23:16]) * 16'(w)));
      res.g   = sat_add(acc.g, div255r(16'(rgb[15:8])  * 16'(w)));
      res.b   = sat_add(acc.b, div255r(16'(rgb[7:0])   * 16'(w)));
      res.cov = acc.cov + w;
    end
    return res;
  endfunction
endpackage

// File: rtl/cbuf_bank.sv
module cbuf_bank
  import cbuf_pkg::*;
#(
  parameter int DEPTH  = 144,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  cell_t             wdata,
  input  logic [ADDR_W-1:0] raddr,
  output cell_t             rdata
);
  cell_t mem [DEPTH];

  // read-first single-clock RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cbuf_blend_pipe.sv
module cbuf_blend_pipe
  import cbuf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_bank,
  input  logic [23:0]       in_rgb,
  input  logic [7:0]        in_alpha,
  input  cell_t             rd_cell,
  output logic              s1_bank,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [ADDR_W-1:0] wr_addr,
  output cell_t             wr_cell
);
  logic              s1_valid;
  logic [ADDR_W-1:0] s1_addr;
  logic [23:0]       s1_rgb;
  logic [7:0]        s1_alpha;
  logic              f_valid;
  logic              f_bank;
  logic [ADDR_W-1:0] f_addr;
  cell_t             f_cell;
  cell_t             old_cell;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      f_valid  <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      f_valid  <= s1_valid;
    end
    s1_addr  <= in_addr;
    s1_bank  <= in_bank;
    s1_rgb   <= in_rgb;
    s1_alpha <= in_alpha;
    f_bank   <= s1_bank;
    f_addr   <= s1_addr;
    f_cell   <= wr_cell;
  end

  // the RAM read issued with the previous write returns pre-write data
  always_comb begin
    old_cell = rd_cell;
    if (f_valid && f_addr == s1_addr && f_bank == s1_bank) old_cell = f_cell;
  end

  assign wr_cell = blend_under(old_cell, s1_rgb, s1_alpha);
  assign wr_en   = s1_valid;
  assign wr_bank = s1_bank;
  assign wr_addr = s1_addr;

  // R3
  cov_grow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_cell.cov >= old_cell.cov);
  // R5
  fwd_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && f_valid && f_addr == s1_addr && f_bank == s1_bank) |-> wr_cell.cov >= f_cell.cov);
endmodule

// File: rtl/cbuf_ctrl.sv
module cbuf_ctrl #(
  parameter int DEPTH  = 144,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              band_end,
  input  logic              disp_start,
  output logic              comp_ready,
  output logic              comp_bank,
  output logic [1:0]        clr_mask,
  output logic [ADDR_W-1:0] clr_addr,
  output logic              scan_rd,
  output logic              scan_bank,
  output logic              underrun,
  output logic              rd_v,
  output logic              rd_last,
  output logic              rd_bank
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic              init_q;
  logic [ADDR_W-1:0] init_cnt;
  logic              comp_bank_q, comp_bank_d;
  logic [1:0]        full_q, full_d;
  logic              scan_on_q, scan_on_d;
  logic              scan_ptr_q, scan_ptr_d;
  logic [ADDR_W-1:0] scan_addr_q, scan_addr_d;

  assign comp_ready = !init_q && !full_q[comp_bank_q];
  assign comp_bank  = comp_bank_q;
  assign scan_rd    = scan_on_q;
  assign scan_bank  = scan_ptr_q;
  assign clr_addr   = init_q ? init_cnt : scan_addr_q;

  always_comb begin
    clr_mask = 2'b00;
    if (init_q)         clr_mask = 2'b11;
    else if (scan_on_q) clr_mask = scan_ptr_q ? 2'b10 : 2'b01;
  end

  always_comb begin
    full_d      = full_q;
    comp_bank_d = comp_bank_q;
    scan_on_d   = scan_on_q;
    scan_ptr_d  = scan_ptr_q;
    scan_addr_d = scan_addr_q;
    if (band_end && comp_ready) begin
      full_d[comp_bank_q] = 1'b1;
      comp_bank_d         = !comp_bank_q;
    end
    if (scan_on_q) begin
      if (scan_addr_q == LAST) begin
        scan_on_d          = 1'b0;
        full_d[scan_ptr_q] = 1'b0;
        scan_ptr_d         = !scan_ptr_q;
        scan_addr_d        = '0;
      end else begin
        scan_addr_d = scan_addr_q + 1'b1;
      end
    end else if (disp_start && full_q[scan_ptr_q]) begin
      scan_on_d   = 1'b1;
      scan_addr_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q      <= 1'b1;
      init_cnt    <= '0;
      comp_bank_q <= 1'b0;
      full_q      <= 2'b00;
      scan_on_q   <= 1'b0;
      scan_ptr_q  <= 1'b0;
      scan_addr_q <= '0;
      underrun    <= 1'b0;
      rd_v        <= 1'b0;
      rd_last     <= 1'b0;
      rd_bank     <= 1'b0;
    end else begin
      if (init_q) begin
        init_cnt <= init_cnt + 1'b1;
        if (init_cnt == LAST) init_q <= 1'b0;
      end
      comp_bank_q <= comp_bank_d;
      full_q      <= full_d;
      scan_on_q   <= scan_on_d;
      scan_ptr_q  <= scan_ptr_d;
      scan_addr_q <= scan_addr_d;
      underrun    <= disp_start && !scan_on_q && !full_q[scan_ptr_q];
      rd_v        <= scan_on_q;
      rd_last     <= scan_on_q && scan_addr_q == LAST;
      rd_bank     <= scan_ptr_q;
    end
  end

  // R8
  banks_apart_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_on_q && comp_ready) |-> scan_ptr_q != comp_bank_q);
  // R9
  underrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |-> ($past(disp_start) && !rd_v));
  // R6
  scan_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(scan_on_q) |-> scan_addr_q == '0);
endmodule

// File: rtl/layer_band_compositor.sv
module layer_band_compositor
  import cbuf_pkg::*;
#(
  parameter int BAND_W = 48,
  parameter int BAND_H = 3,
  parameter int X_W    = $clog2(BAND_W),
  parameter int Y_W    = $clog2(BAND_H)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pix_valid,
  input  logic [X_W-1:0] pix_x,
  input  logic [Y_W-1:0] pix_y,
  input  logic [23:0]    pix_rgb,
  input  logic [7:0]     pix_alpha,
  input  logic           band_end,
  output logic           comp_ready,
  input  logic           disp_start,
  output logic           out_valid,
  output logic [23:0]    out_rgb,
  output logic           band_done,
  output logic           underrun
);
  localparam int DEPTH  = BAND_W * BAND_H;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int NBANK  = 2;

  logic              in_range, accept, comp_bank;
  logic [ADDR_W-1:0] in_addr, clr_addr, wr_addr;
  logic [1:0]        clr_mask;
  logic              scan_rd, scan_bank, rd_v, rd_last, rd_bank;
  logic              s1_bank, wr_en, wr_bank;
  cell_t             wr_cell;
  logic              bk_we    [NBANK];
  logic [ADDR_W-1:0] bk_waddr [NBANK];
  logic [ADDR_W-1:0] bk_raddr [NBANK];
  cell_t             bk_wdata [NBANK];
  cell_t             bk_rd    [NBANK];

  assign in_range = (int'(pix_x) < BAND_W) && (int'(pix_y) < BAND_H);
  assign accept   = pix_valid && comp_ready && in_range;
  assign in_addr  = ADDR_W'(int'(pix_y) * BAND_W + int'(pix_x));

  cbuf_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .band_end(band_end), .disp_start(disp_start),
    .comp_ready(comp_ready), .comp_bank(comp_bank), .clr_mask(clr_mask),
    .clr_addr(clr_addr), .scan_rd(scan_rd), .scan_bank(scan_bank),
    .underrun(underrun), .rd_v(rd_v), .rd_last(rd_last), .rd_bank(rd_bank)
  );

  cbuf_blend_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk(clk), .rst(rst), .in_valid(accept), .in_addr(in_addr),
    .in_bank(comp_bank), .in_rgb(pix_rgb), .in_alpha(pix_alpha),
    .rd_cell(bk_rd[s1_bank]), .s1_bank(s1_bank), .wr_en(wr_en),
    .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_cell(wr_cell)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bk_we[b]    = clr_mask[b] || (wr_en && wr_bank == 1'(b));
    assign bk_waddr[b] = clr_mask[b] ? clr_addr : wr_addr;
    assign bk_wdata[b] = clr_mask[b] ? '0 : wr_cell;
    assign bk_raddr[b] = (scan_rd && scan_bank == 1'(b)) ? clr_addr : in_addr;

    cbuf_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .we(bk_we[b]), .waddr(bk_waddr[b]), .wdata(bk_wdata[b]),
      .raddr(bk_raddr[b]), .rdata(bk_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      band_done <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= rd_v;
      band_done <= rd_v && rd_last;
      out_rgb   <= {bk_rd[rd_bank].r, bk_rd[rd_bank].g, bk_rd[rd_bank].b};
    end
  end

  // R6
  done_with_pixel_chk: assert property (@(posedge clk) disable iff (rst)
    band_done |-> out_valid);
  // R6
  out_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(rd_v));
endmodule

// File: tb/tb_layer_band_compositor.sv
module tb_layer_band_compositor;
  localparam int W = 48;
  localparam int H = 3;
  localparam int DEPTH = W * H;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_valid = 1'b0;
  logic [5:0]  pix_x = '0;
  logic [1:0]  pix_y = '0;
  logic [23:0] pix_rgb = '0;
  logic [7:0]  pix_alpha = '0;
  logic        band_end = 1'b0;
  logic        disp_start = 1'b0;
  logic        comp_ready, out_valid, band_done, underrun;
  logic [23:0] out_rgb;

  int checks = 0;
  int errors = 0;
  int mcomp = 0;
  int mscan = 0;
  bit finished = 0;
  logic [31:0] mdl [2][DEPTH];
  logic [23:0] got [DEPTH];

  always #2 clk = ~clk;

  layer_band_compositor #(.BAND_W(W), .BAND_H(H)) dut (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .pix_rgb(pix_rgb), .pix_alpha(pix_alpha), .band_end(band_end),
    .comp_ready(comp_ready), .disp_start(disp_start), .out_valid(out_valid),
    .out_rgb(out_rgb), .band_done(band_done), .underrun(underrun)
  );

  function automatic int m_div(int x);
    return (2 * x + 255) / 510;
  endfunction

  function automatic logic [31:0] m_blend(logic [31:0] acc, logic [23:0] c, int a);
    int k, w, r, g, b;
    k = acc[7:0];
    if (k == 255) return acc;
    w = m_div(a * (255 - k));
    r = acc[31:24] + m_div(c[23:16] * w); if (r > 255) r = 255;
    g = acc[23:16] + m_div(c[15:8] * w);  if (g > 255) g = 255;
    b = acc[15:8]  + m_div(c[7:0] * w);   if (b > 255) b = 255;
    return {8'(r), 8'(g), 8'(b), 8'(k + w)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(int x, int y, logic [23:0] c, int a);
    @(negedge clk);
    while (!comp_ready) begin pix_valid = 1'b0; @(negedge clk); end
    pix_valid = 1'b1; pix_x = 6'(x); pix_y = 2'(y); pix_rgb = c; pix_alpha = 8'(a);
    if (x < W && y < H) mdl[mcomp][y * W + x] = m_blend(mdl[mcomp][y * W + x], c, a);
  endtask

  task automatic end_band();
    @(negedge clk);
    while (!comp_ready) begin pix_valid = 1'b0; @(negedge clk); end
    pix_valid = 1'b0; band_end = 1'b1;
    @(negedge clk);
    band_end = 1'b0;
    mcomp ^= 1;
  endtask

  task automatic scan_chk(string req);
    @(negedge clk); disp_start = 1'b1;
    @(negedge clk); disp_start = 1'b0;
    chk(out_valid == 1'b0, "R6", "latency cycle1", 32'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6", "latency cycle2", 32'(out_valid), 0);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      got[i] = out_rgb;
      chk(out_valid == 1'b1, "R6", "valid run", 32'(out_valid), 1);
      chk(band_done == (i == DEPTH - 1), "R6", "band_done place", 32'(band_done), 32'(i == DEPTH - 1));
      chk(out_rgb == mdl[mscan][i][31:8], req, $sformatf("pixel %0d", i), 32'(out_rgb), 32'(mdl[mscan][i][31:8]));
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R6", "valid ends", 32'(out_valid), 0);
    for (int i = 0; i < DEPTH; i++) mdl[mscan][i] = '0;
    mscan ^= 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd7331));
    for (int b = 0; b < 2; b++) for (int i = 0; i < DEPTH; i++) mdl[b][i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 0 && band_done == 0 && underrun == 0, "R1", "outputs after reset",
        {out_valid, band_done, underrun}, 0);
    chk(comp_ready == 1'b0, "R1", "ready low in sweep", 32'(comp_ready), 0);
    n = 0;
    while (!comp_ready && n < 1000) begin @(negedge clk); n++; end
    chk(n == DEPTH, "R1", "sweep length", n, DEPTH);

    // R9: request with nothing ready
    @(negedge clk); disp_start = 1'b1;
    @(negedge clk); disp_start = 1'b0;
    chk(underrun == 1'b1, "R9", "underrun raised", 32'(underrun), 1);
    @(negedge clk);
    chk(underrun == 1'b0 && out_valid == 1'b0, "R9", "underrun one cycle", {underrun, out_valid}, 0);

    // band A, buffer 0: directed corners then random row 2
    push(5, 1, 24'hC86432, 128);                       // R2
    push(0, 0, 24'hC86432, 128);                       // R3
    push(0, 0, 24'h0000FF, 200);
    push(1, 0, 24'h102030, 255);                       // R4
    push(1, 0, 24'hFFFFFF, 255);
    push(1, 0, 24'hFFFFFF, 90);
    for (int i = 0; i < 4; i++) push(2, 0, 24'h808080, 64);   // R5 back-to-back
    push(50, 0, 24'hFFFFFF, 255);                      // R11 would alias to (2,1)
    for (int i = 0; i < 120; i++) push($urandom_range(63), 2, 24'($urandom), $urandom_range(255));
    end_band();
    scan_chk("R1");
    chk(got[W + 5] == {8'(m_div(200 * 128)), 8'(m_div(100 * 128)), 8'(m_div(50 * 128))},
        "R2", "single pixel", 32'(got[W + 5]),
        {8'h0, 8'(m_div(200 * 128)), 8'(m_div(100 * 128)), 8'(m_div(50 * 128))});
    begin
      int w2, cb;
      w2 = m_div(200 * (255 - 128));
      cb = m_div(50 * 128) + m_div(255 * w2); if (cb > 255) cb = 255;
      chk(got[0] == {8'(m_div(200 * 128)), 8'(m_div(100 * 128)), 8'(cb)}, "R3", "under blend",
          32'(got[0]), {8'h0, 8'(m_div(200 * 128)), 8'(m_div(100 * 128)), 8'(cb)});
    end
    chk(got[1] == 24'h102030, "R4", "opaque holds", 32'(got[1]), 32'h102030);
    chk(got[W + 2] == 24'h0, "R11", "out of range dropped", 32'(got[W + 2]), 0);
    begin
      logic [31:0] e;
      e = '0;
      for (int i = 0; i < 4; i++) e = m_blend(e, 24'h808080, 64);
      chk(got[2] == e[31:8], "R5", "same spot burst", 32'(got[2]), 32'(e[31:8]));
    end

    // band B, buffer 1
    for (int i = 0; i < 150; i++)
      push($urandom_range(63), $urandom_range(3), 24'($urandom),
           ($urandom_range(3) == 0) ? 255 : $urandom_range(255));
    end_band();

    // scan B while composing C into the reused buffer 0
    fork
      scan_chk("R8");
      begin
        repeat (6) @(negedge clk);
        chk(comp_ready == 1'b1, "R8", "ready during scan", 32'(comp_ready), 1);
        for (int i = 0; i < 100; i++)
          push($urandom_range(47), $urandom_range(2), 24'($urandom), $urandom_range(255));
        end_band();
      end
    join

    // band D, buffer 1, then both full
    for (int i = 0; i < 60; i++)
      push($urandom_range(47), $urandom_range(2), 24'($urandom), $urandom_range(255));
    end_band();
    @(negedge clk);
    chk(comp_ready == 1'b0, "R10", "ready low when full", 32'(comp_ready), 0);
    pix_valid = 1'b1; pix_x = 6'd0; pix_y = 2'd0; pix_rgb = 24'hFFFFFF; pix_alpha = 8'd255;
    band_end = 1'b1;
    repeat (3) @(negedge clk);
    pix_valid = 1'b0; band_end = 1'b0;
    scan_chk("R7");
    @(negedge clk);
    chk(comp_ready == 1'b1, "R10", "ready back after scan", 32'(comp_ready), 1);
    scan_chk("R10");
    @(negedge clk); disp_start = 1'b1;
    @(negedge clk); disp_start = 1'b0;
    chk(underrun == 1'b1, "R10", "ignored band_end left no band", 32'(underrun), 1);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule